// File: doc/BRIEF.md
# Calendar Alarm Match Comparator

This block decides when a calendar alarm is due. A timekeeping core outside the block supplies the current time as BCD seconds, minutes and hours, a one-hot weekday and a BCD day of the month. It also supplies a strobe that pulses for one clock each time the seconds count advances. On every such strobe the block compares the current time with four programmed alarm fields. If the comparison succeeds, it sets an alarm flag. When interrupts are enabled, it also pulls an active-low interrupt line.

Software programs the block through a small write port. Each alarm field has its own ignore bit, which takes that field out of the comparison. A control bit chooses the meaning of the fourth field. It is either a weekday mask, in which several days may be chosen at once, or a single day of the month. The flag stays set until software writes a zero to it. The interrupt line is released as soon as the flag clears or the interrupt enable is turned off.

Top module: `cal_alarm_cmp`

## Requirements
- R1: After a synchronous reset, `alarm_flag` is 0 and `irq_n` is 1. The seconds, minutes, hours and day alarm registers hold 0, and both control bits are 0.
- R2: Bit 7 of each alarm register is the ignore bit. When it is 1, that field matches whatever the current value is.
- R3: A match requires every field that is not ignored to agree. The comparison is made only in a cycle where `sec_tick` is 1. Without `sec_tick`, the flag never sets.
- R4: When control bit 1 is 0 (weekday mode), bits 6..0 of the day register form a day mask: bit 0 is Sunday, bit 1 is Monday, and so on up to bit 6 for Saturday. The field matches when any mask bit lines up with the set bit of the one-hot `cur_wday`.
- R5: When control bit 1 is 1 (date mode), bits 6..0 of the day register are compared with bits 6..0 of `cur_date`, and `cur_wday` has no effect.
- R6: A match on a `sec_tick` cycle sets `alarm_flag` at the next clock edge. Writing select 5 with data bit 0 = 0 clears the flag, and writing data bit 0 = 1 leaves it unchanged. If a set and a clear fall in the same cycle, the set wins.
- R7: `irq_n` is driven low only while `alarm_flag` is 1 and the interrupt enable (control bit 0) is 1. A change of the enable reaches `irq_n` one cycle after the write takes effect. A flag set or clear reaches `irq_n` in the same cycle as the flag.
- R8: When all four ignore bits are set, the flag sets on every `sec_tick`, whatever the time inputs hold.
- R9: While the time still matches, each later `sec_tick` sets the flag again after software has cleared it. Example: day mask 3Eh, hour 07h, minute 00h, seconds ignored fires on every tick from Monday to Friday between 7:00:00 and 7:00:59.
- R10: Write selects are 0 = seconds, 1 = minutes, 2 = hours, 3 = day, 4 = control (bit 0 interrupt enable, bit 1 date mode) and 5 = flag. A write takes effect at the clock edge on which `wr_en` is sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sec_tick | input | 1 | One-cycle strobe on each seconds advance |
| cur_sec | input | 8 | Current seconds, BCD |
| cur_min | input | 8 | Current minutes, BCD |
| cur_hour | input | 8 | Current hours, BCD |
| cur_wday | input | 7 | Current weekday, one-hot, bit 0 is Sunday |
| cur_date | input | 8 | Current day of month, BCD |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select for the write |
| wr_data | input | 8 | Write data |
| alarm_flag | output | 1 | Sticky alarm flag |
| irq_n | output | 1 | Active-low interrupt; 1 means released |

## Verification
A wrong ignore bit or a wrong mode decode in the comparator shows at `alarm_flag` one clock after the next `sec_tick`. It appears either as a flag that never rises at a matching time or as one that rises at a time that should not match. A flag register that misses a clear or a set-over-clear collision is visible on the edge after the write. A wrong interrupt gate shows on `irq_n` within one cycle of a flag or enable change. Directed cases around the weekday mask, date mode and the all-ignored setting are mixed with randomly chosen times and alarms. Half of the random alarms are copied from the time, so matches occur often.

// File: rtl/cal_alarm_pkg.sv
package cal_alarm_pkg;
  typedef enum logic [2:0] {
    SEL_SEC  = 3'd0,
    SEL_MIN  = 3'd1,
    SEL_HOUR = 3'd2,
    SEL_DAY  = 3'd3,
    SEL_CTRL = 3'd4,
    SEL_FLAG = 3'd5
  } reg_sel_e;

  localparam int unsigned CTRL_IRQ_EN_BIT = 0;
  localparam int unsigned CTRL_DATE_BIT   = 1;
  localparam int unsigned NUM_TIME_FIELDS = 3;
endpackage

// File: rtl/cal_alarm_regs.sv
module cal_alarm_regs
  import cal_alarm_pkg::*;
#(
  parameter int unsigned FIELD_W = 8,
  parameter int unsigned DAYS    = 7
) (
  input  logic                                      clk,
  input  logic                                      rst,
  input  logic                                      wr_en,
  input  logic [2:0]                                wr_sel,
  input  logic [FIELD_W-1:0]                        wr_data,
  output logic [NUM_TIME_FIELDS-1:0][FIELD_W-1:0]   alm_time,
  output logic [FIELD_W-1:0]                        alm_day,
  output logic                                      date_mode,
  output logic                                      irq_en,
  output logic                                      clr_req
);
  always_ff @(posedge clk) begin
    if (rst) begin
      alm_time  <= '0;
      alm_day   <= '0;
      date_mode <= 1'b0;
      irq_en    <= 1'b0;
    end else if (wr_en) begin
      case (reg_sel_e'(wr_sel))
        SEL_SEC:  alm_time[0] <= wr_data;
        SEL_MIN:  alm_time[1] <= wr_data;
        SEL_HOUR: alm_time[2] <= wr_data;
        SEL_DAY:  alm_day     <= wr_data;
        SEL_CTRL: begin
          irq_en    <= wr_data[CTRL_IRQ_EN_BIT];
          date_mode <= wr_data[CTRL_DATE_BIT];
        end
        default: ;
      endcase
    end
  end

  // Only a zero written to the flag select clears; a one is dropped here.
  assign clr_req = wr_en && (reg_sel_e'(wr_sel) == SEL_FLAG) && !wr_data[0];
endmodule

// File: rtl/cal_alarm_match.sv
module cal_alarm_match
  import cal_alarm_pkg::*;
#(
  parameter int unsigned FIELD_W = 8,
  parameter int unsigned DAYS    = 7
) (
  input  logic                                    clk,
  input  logic                                    rst,
  input  logic [NUM_TIME_FIELDS-1:0][FIELD_W-1:0] alm_time,
  input  logic [NUM_TIME_FIELDS-1:0][FIELD_W-1:0] cur_time,
  input  logic [FIELD_W-1:0]                      alm_day,
  input  logic [DAYS-1:0]                         cur_wday,
  input  logic [FIELD_W-1:0]                      cur_date,
  input  logic                                    date_mode,
  output logic                                    match
);
  localparam int unsigned IGN = FIELD_W - 1;
  localparam int unsigned VW  = FIELD_W - 1;

  logic [NUM_TIME_FIELDS-1:0] field_ok;
  logic                       day_hit;
  logic                       day_ok;

  for (genvar i = 0; i < NUM_TIME_FIELDS; i++) begin : g_field
    assign field_ok[i] = alm_time[i][IGN] ||
                         (alm_time[i][VW-1:0] == cur_time[i][VW-1:0]);
  end

  always_comb begin
    if (date_mode) day_hit = (alm_day[VW-1:0] == cur_date[VW-1:0]);
    else           day_hit = |(alm_day[DAYS-1:0] & cur_wday);
  end

  assign day_ok = alm_day[IGN] || day_hit;
  assign match  = day_ok && (&field_ok);

  AST_ALL_IGNORED_MATCHES: assert property (@(posedge clk) disable iff (rst)
    (alm_day[IGN] && alm_time[0][IGN] && alm_time[1][IGN] && alm_time[2][IGN]) |-> match); // R8
  AST_EMPTY_MASK_NO_MATCH: assert property (@(posedge clk) disable iff (rst)
    (!date_mode && !alm_day[IGN] && ((alm_day[DAYS-1:0] & cur_wday) == '0)) |-> !match); // R4
endmodule

// File: rtl/cal_alarm_flag.sv
module cal_alarm_flag (
  input  logic clk,
  input  logic rst,
  input  logic sec_tick,
  input  logic match,
  input  logic clr_req,
  input  logic irq_en,
  output logic alarm_flag,
  output logic irq_n
);
  logic flag_d;

  always_comb begin
    flag_d = alarm_flag;
    if (clr_req)            flag_d = 1'b0;
    if (sec_tick && match)  flag_d = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      alarm_flag <= 1'b0;
      irq_n      <= 1'b1;
    end else begin
      alarm_flag <= flag_d;
      irq_n      <= ~(flag_d & irq_en);
    end
  end

  AST_NO_SET_WITHOUT_TICK: assert property (@(posedge clk) disable iff (rst)
    (!(sec_tick && match) && !alarm_flag) |=> !alarm_flag); // R3
  AST_SET_ON_MATCH: assert property (@(posedge clk) disable iff (rst)
    (sec_tick && match) |=> alarm_flag); // R6
  AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (rst)
    (clr_req && !(sec_tick && match)) |=> !alarm_flag); // R6
  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (rst)
    !irq_n |-> alarm_flag); // R7
endmodule

// File: rtl/cal_alarm_cmp.sv
module cal_alarm_cmp
  import cal_alarm_pkg::*;
#(
  parameter int unsigned FIELD_W = 8,
  parameter int unsigned DAYS    = 7
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               sec_tick,
  input  logic [FIELD_W-1:0] cur_sec,
  input  logic [FIELD_W-1:0] cur_min,
  input  logic [FIELD_W-1:0] cur_hour,
  input  logic [DAYS-1:0]    cur_wday,
  input  logic [FIELD_W-1:0] cur_date,
  input  logic               wr_en,
  input  logic [2:0]         wr_sel,
  input  logic [FIELD_W-1:0] wr_data,
  output logic               alarm_flag,
  output logic               irq_n
);
  logic [NUM_TIME_FIELDS-1:0][FIELD_W-1:0] alm_time;
  logic [NUM_TIME_FIELDS-1:0][FIELD_W-1:0] cur_time;
  logic [FIELD_W-1:0]                      alm_day;
  logic                                    date_mode;
  logic                                    irq_en;
  logic                                    clr_req;
  logic                                    match;

  assign cur_time = {cur_hour, cur_min, cur_sec};

  cal_alarm_regs #(.FIELD_W(FIELD_W), .DAYS(DAYS)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .alm_time(alm_time), .alm_day(alm_day), .date_mode(date_mode),
    .irq_en(irq_en), .clr_req(clr_req)
  );

  cal_alarm_match #(.FIELD_W(FIELD_W), .DAYS(DAYS)) u_match (
    .clk(clk), .rst(rst), .alm_time(alm_time), .cur_time(cur_time),
    .alm_day(alm_day), .cur_wday(cur_wday), .cur_date(cur_date),
    .date_mode(date_mode), .match(match)
  );

  cal_alarm_flag u_flag (
    .clk(clk), .rst(rst), .sec_tick(sec_tick), .match(match),
    .clr_req(clr_req), .irq_en(irq_en), .alarm_flag(alarm_flag), .irq_n(irq_n)
  );

  AST_RESET_QUIET: assert property (@(posedge clk)
    $past(rst) |-> (!alarm_flag && irq_n)); // R1
endmodule

// File: tb/cal_alarm_cmp_test.sv
module cal_alarm_cmp_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sec_tick = 1'b0;
  logic [7:0] cur_sec = '0, cur_min = '0, cur_hour = '0, cur_date = 8'h01;
  logic [6:0] cur_wday = 7'h01;
  logic       wr_en = 1'b0;
  logic [2:0] wr_sel = '0;
  logic [7:0] wr_data = '0;
  logic       alarm_flag, irq_n;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // bench model of programmed values
  logic [7:0] m_sec = 0, m_min = 0, m_hour = 0, m_day = 0;
  logic       m_date = 0, m_aie = 0;

  always #2.5 clk = ~clk;

  cal_alarm_cmp uut (
    .clk(clk), .rst(rst), .sec_tick(sec_tick), .cur_sec(cur_sec), .cur_min(cur_min),
    .cur_hour(cur_hour), .cur_wday(cur_wday), .cur_date(cur_date), .wr_en(wr_en),
    .wr_sel(wr_sel), .wr_data(wr_data), .alarm_flag(alarm_flag), .irq_n(irq_n)
  );

  function automatic logic [7:0] bcd(input int v);
    return 8'(((v / 10) << 4) | (v % 10));
  endfunction

  function automatic logic exp_match();
    logic ok;
    ok = (m_sec[7]  || m_sec[6:0]  == cur_sec[6:0]) &&
         (m_min[7]  || m_min[6:0]  == cur_min[6:0]) &&
         (m_hour[7] || m_hour[6:0] == cur_hour[6:0]);
    if (!m_day[7]) begin
      if (m_date) ok = ok && (m_day[6:0] == cur_date[6:0]);
      else        ok = ok && ((m_day[6:0] & cur_wday) != 0);
    end
    return ok;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] sel, input logic [7:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    case (sel)
      3'd0: m_sec = d;
      3'd1: m_min = d;
      3'd2: m_hour = d;
      3'd3: m_day = d;
      3'd4: begin m_aie = d[0]; m_date = d[1]; end
      default: ;
    endcase
    cyc();
    wr_en = 1'b0;
  endtask

  task automatic tick();
    sec_tick = 1'b1;
    cyc();
    sec_tick = 1'b0;
  endtask

  task automatic set_time(input int s, input int m, input int h, input int wd, input int dt);
    cur_sec = bcd(s); cur_min = bcd(m); cur_hour = bcd(h);
    cur_wday = 7'(1 << wd); cur_date = bcd(dt);
  endtask

  initial begin
    #(5.0 * 150000);
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    n_fail++;
    if (!done) begin
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks + 1, n_fail);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = 32'd7321;
    void'($urandom(seed));
    @(negedge clk); cyc(); cyc();
    rst = 1'b0;
    check(alarm_flag == 1'b0, "R1 flag after reset", alarm_flag, 0);
    check(irq_n == 1'b1, "R1 irq after reset", irq_n, 1);
    // R1: zeroed alarms with empty day mask never match
    set_time(0, 0, 0, 0, 1);
    tick();
    check(alarm_flag == 1'b0, "R1 reset registers do not match", alarm_flag, 0);

    // R8: all ignored fires on every tick
    wr(3'd0, 8'h80); wr(3'd1, 8'h80); wr(3'd2, 8'h80); wr(3'd3, 8'h80);
    set_time(37, 12, 23, 4, 29);
    sec_tick = 1'b0; cyc();
    check(alarm_flag == 1'b0, "R3 no tick no set", alarm_flag, 0);
    tick();
    check(alarm_flag == 1'b1, "R8 all ignored fires", alarm_flag, 1);
    check(irq_n == 1'b1, "R7 irq held while disabled", irq_n, 1);
    // R6: write one ignored, zero clears
    wr(3'd5, 8'h01);
    check(alarm_flag == 1'b1, "R6 write one ignored", alarm_flag, 1);
    wr(3'd5, 8'h00);
    check(alarm_flag == 1'b0, "R6 write zero clears", alarm_flag, 0);
    wr(3'd5, 8'h01);
    check(alarm_flag == 1'b0, "R6 write one does not set", alarm_flag, 0);
    set_time(5, 40, 2, 6, 3);
    tick();
    check(alarm_flag == 1'b1, "R8 fires on next tick", alarm_flag, 1);
    // R7: enable interrupt, irq one cycle after write
    wr(3'd4, 8'h01);
    check(irq_n == 1'b1, "R7 enable lag", irq_n, 1);
    cyc();
    check(irq_n == 1'b0, "R7 irq low flag and enable", irq_n, 0);
    wr(3'd5, 8'h00);
    check(irq_n == 1'b1, "R7 clear releases irq", irq_n, 1);
    // R6: set wins over clear in same cycle
    wr_en = 1'b1; wr_sel = 3'd5; wr_data = 8'h00; sec_tick = 1'b1;
    cyc();
    wr_en = 1'b0; sec_tick = 1'b0;
    check(alarm_flag == 1'b1, "R6 set wins over clear", alarm_flag, 1);
    check(irq_n == 1'b0, "R7 irq with set", irq_n, 0);
    wr(3'd4, 8'h00);
    cyc();
    check(irq_n == 1'b1, "R7 disable releases irq", irq_n, 1);
    wr(3'd5, 8'h00);

    // R4/R9: weekday mask 3E, 07:00, seconds ignored
    wr(3'd3, 8'h3E); wr(3'd2, 8'h07); wr(3'd1, 8'h00); wr(3'd0, 8'h80);
    set_time(0, 0, 7, 1, 10);
    tick();
    check(alarm_flag == 1'b1, "R4 Monday 7:00 matches", alarm_flag, 1);
    wr(3'd5, 8'h00);
    set_time(30, 0, 7, 5, 10);
    tick();
    check(alarm_flag == 1'b1, "R9 refires within minute", alarm_flag, 1);
    wr(3'd5, 8'h00);
    set_time(59, 0, 7, 0, 10);
    tick();
    check(alarm_flag == 1'b0, "R4 Sunday excluded", alarm_flag, 0);
    set_time(59, 0, 7, 6, 10);
    tick();
    check(alarm_flag == 1'b0, "R4 Saturday excluded", alarm_flag, 0);
    set_time(0, 1, 7, 3, 10);
    tick();
    check(alarm_flag == 1'b0, "R3 minute mismatch", alarm_flag, 0);
    // R2: ignore the minute field
    wr(3'd1, 8'h80);
    tick();
    check(alarm_flag == 1'b1, "R2 ignored minute matches", alarm_flag, 1);
    wr(3'd5, 8'h00);

    // R5: date mode
    wr(3'd4, 8'h02); wr(3'd3, 8'h15); wr(3'd2, 8'h80); wr(3'd1, 8'h80);
    set_time(0, 0, 0, 0, 15);
    cur_wday = 7'h00;
    tick();
    check(alarm_flag == 1'b1, "R5 date 15 matches", alarm_flag, 1);
    wr(3'd5, 8'h00);
    set_time(0, 0, 0, 3, 16);
    tick();
    check(alarm_flag == 1'b0, "R5 date 16 no match", alarm_flag, 0);

    // random trials (R3 R4 R5 R6 R7 R10)
    for (int t = 0; t < 400; t++) begin
      logic e;
      set_time($urandom % 60, $urandom % 60, $urandom % 24, $urandom % 7, 1 + $urandom % 31);
      wr(3'd4, 8'($urandom % 4));
      wr(3'd0, ($urandom % 2) ? cur_sec  : (8'($urandom) & 8'hFF));
      wr(3'd1, ($urandom % 2) ? cur_min  : (8'($urandom) & 8'hFF));
      wr(3'd2, ($urandom % 2) ? cur_hour : (8'($urandom) & 8'hFF));
      if ($urandom % 2) wr(3'd3, m_date ? cur_date : {1'b0, cur_wday | 7'($urandom)});
      else              wr(3'd3, 8'($urandom));
      wr(3'd5, 8'h00);
      e = exp_match();
      tick();
      check(alarm_flag == e, "R3 random match", alarm_flag, e);
      check(irq_n == !(e && m_aie), "R7 random irq", irq_n, !(e && m_aie));
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule